// File: doc/BRIEF.md
# Sparse Circulant Row Position Generator

This block keeps, as a flat list of counters, the column positions of the set bits in the first row of each circulant block of a sparse parity matrix. One step command moves every counter forward by one column at once, modulo the circulant size r. The list then describes the next row of the quasi-cyclic matrix, without ever building that row in full. A consumer walking a bit-packed dense vector reads any counter back through a read port. The port gives the counter split into a 32-bit word address and a bit offset within that word.

The counters have no order among themselves. A counter that reaches r returns to zero in place through a mask taken from the sign of its incremented value minus r. No counter moves to another slot. Wrapping and non-wrapping counters pass through the same logic in the same cycle, so the step duration gives no hint about which positions are near the top of the row. A load port writes the initial positions one slot at a time. It rejects a position that is not below r and reports that with an error pulse.

Top module: `cgen_rowgen`

## Requirements
- R1: After reset, every slot reads position 0 and `ld_err` is 0.
- R2: A load with `ld_val` below r and `ld_idx` below the slot count (90) writes that slot. The new value reads back from the cycle after the load edge. A load to a slot index of 90 or above changes no slot.
- R3: A load with `ld_val` of r or above leaves every slot unchanged. `ld_err` is 1 for exactly the one cycle after that load edge and 0 after every other edge.
- R4: On a `step` edge, every slot whose value is below r-1 takes its value plus one.
- R5: On a `step` edge, a slot holding r-1 takes 0, so no slot ever reads r or above.
- R6: One step edge updates all slots together in one cycle, whatever the number of slots that wrap.
- R7: When load and step share an edge, the loaded slot takes the loaded value (not incremented) and every other slot steps.
- R8: `rd_pos` shows the slot selected by `rd_idx` without a clock delay. `rd_word` is `rd_pos[15:5]` and `rd_bit` is `rd_pos[4:0]`. A `rd_idx` of 90 or above reads 0 on all three.
- R9: An edge with neither load nor step leaves every slot unchanged.
- R10: Slots keep their identity across wraps: each slot index always reads the position written to it, advanced by the number of steps since then, modulo r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_en | input | 1 | Load one slot this edge |
| ld_idx | input | 7 | Slot to load (block b, entry k at b*45+k) |
| ld_val | input | 16 | Position to load |
| ld_err | output | 1 | Rejected out-of-range load on the previous edge |
| step | input | 1 | Advance every slot to the next row |
| rd_idx | input | 7 | Slot to read |
| rd_pos | output | 16 | Position held by the selected slot |
| rd_word | output | 11 | 32-bit word address of that position |
| rd_bit | output | 5 | Bit offset within that word |

## Verification
The bench builds the block with its defaults: two blocks of 45 slots, 16-bit counters, r of 4801 and 32-bit words. Because r is not a power of two, a wrap at 4800 can be told apart from plain counter overflow. A run of r+5 consecutive steps takes every slot through the wrap at least once and back to its start plus five. Directed loads at r-1 and r-2 in neighbouring slots place several wraps on the same edge. Values at r and at 65535 probe both ends of the rejected range.

// File: rtl/cgen_pkg.sv
package cgen_pkg;
  parameter int CGEN_CW        = 16;
  parameter int CGEN_WORD_BITS = 32;
  parameter int CGEN_BLOCKS    = 2;
  parameter int CGEN_PER_BLOCK = 45;
  parameter int CGEN_R         = 4801;
endpackage

// File: rtl/cgen_rstsync.sv
module cgen_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/cgen_slot.sv
module cgen_slot #(
  parameter int CW = 16,
  parameter int R  = 4801
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_hit,
  input  logic [CW-1:0] ld_val,
  input  logic          step,
  output logic [CW-1:0] pos
);
  localparam logic [CW:0] R_EXT = (CW+1)'(R);

  logic [CW-1:0] pos_q, pos_d;
  logic [CW:0]   inc, diff;
  logic [CW-1:0] keep, wrapped;
  logic          en;

  // Branch-free wrap: the sign of (pos+1-R) builds the mask.
  always_comb begin
    inc     = {1'b0, pos_q} + (CW+1)'(1);
    diff    = inc - R_EXT;
    keep    = {CW{diff[CW]}};
    wrapped = inc[CW-1:0] & keep;
    en      = ld_hit | step;
    pos_d   = ld_hit ? ld_val : wrapped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pos_q <= '0;
    else if (en) pos_q <= pos_d;
  end

  assign pos = pos_q;
endmodule

// File: rtl/cgen_ldguard.sv
module cgen_ldguard #(
  parameter int CW = 16,
  parameter int R  = 4801
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [CW-1:0] ld_val,
  output logic          ld_ok,
  output logic          ld_err
);
  localparam logic [CW:0] R_EXT = (CW+1)'(R);

  logic in_range, err_d, err_q;

  always_comb begin
    in_range = ({1'b0, ld_val} < R_EXT);
    ld_ok    = ld_en & in_range;
    err_d    = ld_en & ~in_range;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign ld_err = err_q;
endmodule

// File: rtl/cgen_rdmux.sv
module cgen_rdmux #(
  parameter int N     = 90,
  parameter int CW    = 16,
  parameter int IDX_W = 7,
  parameter int OFS_W = 5
) (
  input  logic [N-1:0][CW-1:0] pos_all,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [CW-1:0]        rd_pos,
  output logic [CW-OFS_W-1:0]  rd_word,
  output logic [OFS_W-1:0]     rd_bit
);
  logic [CW-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_idx == IDX_W'(i)) sel = pos_all[i];
    end
  end

  assign rd_pos  = sel;
  assign rd_word = sel[CW-1:OFS_W];
  assign rd_bit  = sel[OFS_W-1:0];
endmodule

// File: rtl/cgen_rowgen.sv
module cgen_rowgen
  import cgen_pkg::*;
#(
  parameter int BLOCKS    = CGEN_BLOCKS,
  parameter int PER_BLOCK = CGEN_PER_BLOCK,
  parameter int CW        = CGEN_CW,
  parameter int R         = CGEN_R,
  parameter int WORD_BITS = CGEN_WORD_BITS,
  localparam int N        = BLOCKS * PER_BLOCK,
  localparam int IDX_W    = $clog2(N),
  localparam int OFS_W    = $clog2(WORD_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_en,
  input  logic [IDX_W-1:0]    ld_idx,
  input  logic [CW-1:0]       ld_val,
  output logic                ld_err,
  input  logic                step,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [CW-1:0]       rd_pos,
  output logic [CW-OFS_W-1:0] rd_word,
  output logic [OFS_W-1:0]    rd_bit
);
  logic                srst_n;
  logic                ld_ok;
  logic [N-1:0][CW-1:0] pos_all;

  cgen_rstsync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  cgen_ldguard #(.CW(CW), .R(R)) u_guard (
    .clk    (clk),
    .rst_n  (srst_n),
    .ld_en  (ld_en),
    .ld_val (ld_val),
    .ld_ok  (ld_ok),
    .ld_err (ld_err)
  );

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic hit;
    assign hit = ld_ok & (ld_idx == IDX_W'(g));
    cgen_slot #(.CW(CW), .R(R)) u_slot (
      .clk    (clk),
      .rst_n  (srst_n),
      .ld_hit (hit),
      .ld_val (ld_val),
      .step   (step),
      .pos    (pos_all[g])
    );
  end

  cgen_rdmux #(.N(N), .CW(CW), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_rd (
    .pos_all (pos_all),
    .rd_idx  (rd_idx),
    .rd_pos  (rd_pos),
    .rd_word (rd_word),
    .rd_bit  (rd_bit)
  );
endmodule

// File: rtl/cgen_rowgen_chk.sv
module cgen_rowgen_chk #(
  parameter int CW    = 16,
  parameter int R     = 4801,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_en,
  input logic [IDX_W-1:0] ld_idx,
  input logic [CW-1:0]    ld_val,
  input logic             ld_err,
  input logic             step,
  input logic [IDX_W-1:0] rd_idx,
  input logic [CW-1:0]    rd_pos
);
  localparam logic [CW-1:0] TOP = CW'(R - 1);
  localparam logic [CW-1:0] RV  = CW'(R);

  logic [CW-1:0] nxt;
  logic          bad;
  assign nxt = (rd_pos == TOP) ? '0 : rd_pos + CW'(1);
  assign bad = ld_en && (ld_val >= RV);

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pos < RV); // R5

  AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(step) && !$past(ld_en) && $stable(rd_idx) |-> rd_pos == $past(nxt)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(step) && !$past(ld_en) && $stable(rd_idx) |-> $stable(rd_pos)); // R9

  AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(ld_en) && ($past(ld_val) < RV) && ($past(ld_idx) == rd_idx) |-> rd_pos == $past(ld_val)); // R2

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ld_err == $past(bad)); // R3

  AST_BAD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(bad) && !$past(step) && $stable(rd_idx) |-> $stable(rd_pos)); // R3
endmodule

bind cgen_rowgen cgen_rowgen_chk #(.CW(CW), .R(R), .IDX_W(IDX_W)) chk_i (
  .clk    (clk),
  .rst_n  (srst_n),
  .ld_en  (ld_en),
  .ld_idx (ld_idx),
  .ld_val (ld_val),
  .ld_err (ld_err),
  .step   (step),
  .rd_idx (rd_idx),
  .rd_pos (rd_pos)
);

// File: tb/cgen_rowgen_tb_top.sv
module cgen_rowgen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 90;
  localparam int R  = 4801;
  localparam int CW = 16;

  logic        clk;
  logic        rst_n;
  logic        ld_en;
  logic [6:0]  ld_idx;
  logic [15:0] ld_val;
  logic        ld_err;
  logic        step;
  logic [6:0]  rd_idx;
  logic [15:0] rd_pos;
  logic [10:0] rd_word;
  logic [4:0]  rd_bit;

  int  exp_pos [N];
  int  checks;
  int  errors;
  bit  done;

  cgen_rowgen dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val),
    .ld_err(ld_err), .step(step), .rd_idx(rd_idx), .rd_pos(rd_pos),
    .rd_word(rd_word), .rd_bit(rd_bit)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int next_pos(int v);
    return (v == R - 1) ? 0 : v + 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_slot(int idx, string req);
    int e;
    rd_idx = 7'(idx);
    #1;
    e = (idx < N) ? exp_pos[idx] : 0;
    check(rd_pos == 16'(e) && rd_word == 11'(e >> 5) && rd_bit == 5'(e & 31),
          req, int'(rd_pos), e);
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < N; i++) check_slot(i, req);
  endtask

  task automatic op(bit l, int li, int lv, bit s, string req);
    bit bad;
    @(negedge clk);
    ld_en = l; ld_idx = 7'(li); ld_val = 16'(lv); step = s;
    @(posedge clk);
    #1;
    ld_en = 1'b0; step = 1'b0;
    bad = l && (lv >= R);
    if (s) for (int i = 0; i < N; i++) exp_pos[i] = next_pos(exp_pos[i]);
    if (l && !bad && li < N) exp_pos[li] = lv;
    check(ld_err == bad, req, int'(ld_err), int'(bad));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1cc5_0a7e));
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; ld_en = 1'b0; ld_idx = '0; ld_val = '0; step = 1'b0; rd_idx = '0;
    for (int i = 0; i < N; i++) exp_pos[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #1;
    check(ld_err == 1'b0, "R1 ld_err after reset", int'(ld_err), 0);
    sweep("R1 reset positions");

    // R2 basic load
    op(1, 5, 1234, 0, "R2 load err flag");
    check_slot(5, "R2 load slot 5");
    // R3 rejected loads at both ends
    op(1, 5, R, 0, "R3 err on value r");
    check_slot(5, "R3 slot kept after value r");
    op(1, 6, 65535, 0, "R3 err on max value");
    check_slot(6, "R3 slot kept after max value");
    op(0, 0, 0, 0, "R3 err clears");
    // R2 out-of-range slot index
    op(1, 100, 77, 0, "R2 bad index err");
    sweep("R2 bad index changes nothing");

    // R5 R6 several wraps in one step
    op(1, 0, R - 1, 0, "R5 setup");
    op(1, 1, R - 2, 0, "R5 setup");
    op(1, 44, R - 1, 0, "R5 setup");
    op(1, 45, R - 1, 0, "R5 setup");
    op(1, 89, 0, 0, "R5 setup");
    op(0, 0, 0, 1, "R4 step err flag");
    check_slot(0, "R5 wrap slot 0");
    check_slot(1, "R4 increment slot 1");
    check_slot(44, "R5 wrap slot 44");
    sweep("R6 R10 all slots after multi-wrap step");

    // R7 load and step together
    op(1, 1, 7, 1, "R7 combined err flag");
    check_slot(1, "R7 loaded slot not stepped");
    check_slot(0, "R7 other slot stepped");
    sweep("R7 all slots");

    // R9 idle
    op(0, 0, 0, 0, "R9 idle err flag");
    sweep("R9 hold");

    // R8 split and out-of-range read
    op(1, 10, 4800, 0, "R8 setup");
    op(1, 11, 4799, 0, "R8 setup");
    check_slot(10, "R8 split 4800");
    check_slot(11, "R8 split 4799");
    check_slot(100, "R8 read beyond slots");
    check_slot(127, "R8 read top index");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int kind;
      kind = $urandom_range(0, 9);
      case (kind)
        0, 1, 2: op(1, $urandom_range(0, N-1), $urandom_range(0, R-1), 0, "R2 random load");
        3:       op(1, $urandom_range(0, N-1), $urandom_range(R, 65535), 0, "R3 random bad load");
        4, 5, 6: op(0, 0, 0, 1, "R4 random step");
        7:       op(1, $urandom_range(0, N-1), $urandom_range(R-3, R-1), 1, "R7 random combined");
        8:       op(0, 0, 0, 0, "R9 random idle");
        default: op(1, $urandom_range(N, 127), $urandom_range(0, R-1), 0, "R2 random bad index");
      endcase
      check_slot($urandom_range(0, N-1), "R4 R10 random read");
      check_slot($urandom_range(0, N-1), "R5 R10 random read");
    end
    sweep("R10 after random mix");

    // full period plus five
    for (int k = 0; k < R + 5; k++) op(0, 0, 0, 1, "R6 long run err flag");
    sweep("R5 R10 after full period");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule